// File: doc/BRIEF.md
# 4B/5B Transmit Code-Group Encoder

This block sits on the transmit side of a 100 Mb/s twisted-pair transmitter. On every 25 MHz clock it takes one nibble with its enable and error flags and produces one 5-bit code-group. While the enable is low it fills the line with IDLE. When a packet starts, the first two enabled cycles are replaced by the start-of-stream pair J and K. Later nibbles are translated through the fixed 16-entry 4B/5B map. When the enable drops, the end-of-stream pair T and R is sent, and then IDLE resumes.

A flagged error during an enabled cycle forces the Transmit Error code-group /H/ out in that cycle. The sequence of framing phases is not changed by the error. A configuration bit and a strap input can each disable encoding. While either one is high, a raw 5-bit input is copied to the output and the framer is held in its idle phase. The output is registered, so each code-group appears one clock after the inputs that caused it.

Top module: `tx_4b5b_encoder`

## Requirements
- R1: While reset is asserted, and at the first clock after it is released with the enable low, the output is IDLE (11111).
- R2: Outside a packet, with the enable low, the output is IDLE (11111). The error flag has no effect when the enable is low.
- R3: The first enabled cycle of a packet yields J (11000) and the second yields K (10001). The nibbles of those two cycles are discarded.
- R4: From the third enabled cycle onward, each nibble maps as follows: 0→11110, 1→01001, 2→10100, 3→10101, 4→01010, 5→01011, 6→01110, 7→01111, 8→10010, 9→10011, A→10110, B→10111, C→11010, D→11011, E→11100, F→11101.
- R5: Any enabled cycle that yields J, K or data yields /H/ (00100) instead when the error flag is high. The framing sequence continues as if no error had been flagged.
- R6: The first cycle with the enable low after J, K or data yields T (01101). The next cycle always yields R (00111), whatever the inputs are, and the framer then returns to idle. If the enable is high in the R cycle, that cycle's nibble is lost and the next cycle yields J.
- R7: A packet only one cycle long yields J, then T, then R.
- R8: While the configuration bit or the strap is high, the output is the raw 5-bit input taken at the previous clock, and the framer returns to idle. After bypass is released, a new packet starts with J.
- R9: Every output code-group is registered and reflects the inputs of exactly one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 25 MHz symbol clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Packet enable for the current nibble |
| tx_er | input | 1 | Error flag for the current nibble |
| txd | input | 4 | Transmit data nibble |
| bypass_cfg | input | 1 | Configuration bit that disables encoding |
| bypass_strap | input | 1 | Strap input that disables encoding |
| raw_sym | input | 5 | Raw code-group passed through in bypass |
| code_out | output | 5 | Registered 5-bit code-group |

## Verification
The hardest cases to reach from the ports are the phase edges. These are an error in a J or K cycle, a packet of a single cycle, the enable held high straight through the R cycle, and bypass turned on in the middle of a packet. The stimulus builds each of these from explicit cycle-by-cycle sequences. The bench model keeps its own count of packet phase and predicts every output. This catches a lost nibble after R, a restart with K instead of J, and a framer left active after bypass.

// File: rtl/enc4b5b_pkg.sv
package enc4b5b_pkg;
  localparam int NIB_W = 4;
  localparam int SYM_W = 5;

  typedef logic [SYM_W-1:0] sym_t;
  typedef logic [NIB_W-1:0] nib_t;

  localparam sym_t SYM_IDLE = 5'b11111;
  localparam sym_t SYM_J    = 5'b11000;
  localparam sym_t SYM_K    = 5'b10001;
  localparam sym_t SYM_T    = 5'b01101;
  localparam sym_t SYM_R    = 5'b00111;
  localparam sym_t SYM_H    = 5'b00100;

  typedef enum logic [1:0] {PH_IDLE, PH_SECOND, PH_BODY, PH_TAIL} phase_e;
  typedef enum logic [2:0] {PICK_IDLE, PICK_J, PICK_K, PICK_DATA, PICK_T, PICK_R} pick_e;

  function automatic sym_t map_nibble(input nib_t n);
    sym_t s;
    case (n)
      4'h0: s = 5'b11110;
      4'h1: s = 5'b01001;
      4'h2: s = 5'b10100;
      4'h3: s = 5'b10101;
      4'h4: s = 5'b01010;
      4'h5: s = 5'b01011;
      4'h6: s = 5'b01110;
      4'h7: s = 5'b01111;
      4'h8: s = 5'b10010;
      4'h9: s = 5'b10011;
      4'hA: s = 5'b10110;
      4'hB: s = 5'b10111;
      4'hC: s = 5'b11010;
      4'hD: s = 5'b11011;
      4'hE: s = 5'b11100;
      default: s = 5'b11101;
    endcase
    return s;
  endfunction

  function automatic logic is_carrier(input pick_e p);
    return (p == PICK_J) || (p == PICK_K) || (p == PICK_DATA);
  endfunction
endpackage

// File: rtl/enc_framer.sv
module enc_framer
  import enc4b5b_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   tx_en,
  input  logic   hold_idle,
  output pick_e  pick,
  output phase_e phase
);
  phase_e ph_q, ph_d;

  always_comb begin
    ph_d = ph_q;
    pick = PICK_IDLE;
    if (hold_idle) begin
      ph_d = PH_IDLE;
    end else begin
      case (ph_q)
        PH_IDLE: if (tx_en) begin
          pick = PICK_J;
          ph_d = PH_SECOND;
        end
        PH_SECOND: if (tx_en) begin
          pick = PICK_K;
          ph_d = PH_BODY;
        end else begin
          pick = PICK_T;
          ph_d = PH_TAIL;
        end
        PH_BODY: if (tx_en) begin
          pick = PICK_DATA;
        end else begin
          pick = PICK_T;
          ph_d = PH_TAIL;
        end
        default: begin
          pick = PICK_R;
          ph_d = PH_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_IDLE;
    else        ph_q <= ph_d;
  end

  assign phase = ph_q;

  assert_start_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_SECOND) |-> $past(ph_q == PH_IDLE && tx_en && !hold_idle));

  assert_tail_closes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_TAIL) |=> (ph_q == PH_IDLE));

  assert_hold_forces_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hold_idle |=> (ph_q == PH_IDLE));
endmodule

// File: rtl/enc_sym_select.sv
module enc_sym_select
  import enc4b5b_pkg::*;
(
  input  pick_e pick,
  input  nib_t  txd,
  input  logic  tx_er,
  output logic  err_hit,
  output sym_t  sym
);
  assign err_hit = tx_er && is_carrier(pick);

  always_comb begin
    case (pick)
      PICK_J:    sym = SYM_J;
      PICK_K:    sym = SYM_K;
      PICK_DATA: sym = map_nibble(txd);
      PICK_T:    sym = SYM_T;
      PICK_R:    sym = SYM_R;
      default:   sym = SYM_IDLE;
    endcase
    if (err_hit) sym = SYM_H;
  end
endmodule

// File: rtl/enc_out_reg.sv
module enc_out_reg
  import enc4b5b_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  bypass,
  input  sym_t  raw_sym,
  input  sym_t  sym,
  input  logic  err_hit,
  input  logic  gap,
  output sym_t  code_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      code_q <= SYM_IDLE;
    else if (bypass) code_q <= raw_sym;
    else             code_q <= sym;
  end

  assert_bypass_passthru_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bypass |=> (code_q == $past(raw_sym)));

  assert_error_group_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (err_hit && !bypass) |=> (code_q == SYM_H));

  assert_gap_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (gap && !bypass) |=> (code_q == SYM_IDLE));
endmodule

// File: rtl/tx_4b5b_encoder.sv
module tx_4b5b_encoder
  import enc4b5b_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_en,
  input  logic       tx_er,
  input  logic [3:0] txd,
  input  logic       bypass_cfg,
  input  logic       bypass_strap,
  input  logic [4:0] raw_sym,
  output logic [4:0] code_out
);
  logic   bypass;
  pick_e  pick;
  phase_e phase;
  logic   err_hit;
  logic   gap;
  sym_t   sym;

  assign bypass = bypass_cfg | bypass_strap;
  assign gap    = (pick == PICK_IDLE);

  enc_framer u_framer (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .hold_idle(bypass),
    .pick(pick), .phase(phase)
  );

  enc_sym_select u_select (
    .pick(pick), .txd(txd), .tx_er(tx_er), .err_hit(err_hit), .sym(sym)
  );

  enc_out_reg u_out (
    .clk(clk), .rst_n(rst_n), .bypass(bypass), .raw_sym(raw_sym),
    .sym(sym), .err_hit(err_hit), .gap(gap), .code_q(code_out)
  );

  assert_idle_ignores_error_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE && !tx_en && !bypass) |=> (code_out == SYM_IDLE));

  assert_one_cycle_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass && pick == PICK_DATA && !tx_er) |=> (code_out == $past(map_nibble(txd))));
endmodule

// File: tb/tx_4b5b_encoder_bench.sv
`timescale 1ns/1ps
module tx_4b5b_encoder_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_en = 1'b0, tx_er = 1'b0;
  logic [3:0] txd = 4'h0;
  logic       bypass_cfg = 1'b0, bypass_strap = 1'b0;
  logic [4:0] raw_sym = 5'h0;
  logic [4:0] code_out;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // model state: 0 idle, 1 after J, 2 in body, 3 R pending
  int          m_ph = 0;
  logic [4:0]  exp_code = 5'b11111;
  string       exp_tag = "R1";

  // data table, nibble F first down to nibble 0
  localparam logic [79:0] TABLE = {
    5'b11101, 5'b11100, 5'b11011, 5'b11010, 5'b10111, 5'b10110, 5'b10011, 5'b10010,
    5'b01111, 5'b01110, 5'b01011, 5'b01010, 5'b10101, 5'b10100, 5'b01001, 5'b11110};

  always #2.5 clk = ~clk;

  tx_4b5b_encoder u_tx_4b5b_encoder (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_er(tx_er), .txd(txd),
    .bypass_cfg(bypass_cfg), .bypass_strap(bypass_strap), .raw_sym(raw_sym),
    .code_out(code_out)
  );

  task automatic check(input string tag, input logic [4:0] want);
    checks++;
    if (code_out !== want) begin
      errors++;
      $display("FAIL %s: code_out=%b expected=%b at %0t", tag, code_out, want, $time);
    end
  endtask

  task automatic cyc(input logic en, input logic er, input logic [3:0] d,
                     input logic cfg, input logic strap, input logic [4:0] raw);
    @(negedge clk);
    check(exp_tag, exp_code);
    tx_en = en; tx_er = er; txd = d;
    bypass_cfg = cfg; bypass_strap = strap; raw_sym = raw;
    if (cfg || strap) begin
      exp_code = raw; exp_tag = "R8"; m_ph = 0;
    end else if (m_ph == 3) begin
      exp_code = 5'b00111; exp_tag = "R6"; m_ph = 0;
    end else if (en) begin
      if (m_ph == 0) begin
        exp_code = 5'b11000; exp_tag = "R3"; m_ph = 1;
      end else if (m_ph == 1) begin
        exp_code = 5'b10001; exp_tag = "R3"; m_ph = 2;
      end else begin
        exp_code = TABLE[d*5 +: 5]; exp_tag = "R4/R9";
      end
      if (er) begin
        exp_code = 5'b00100; exp_tag = "R5";
      end
    end else if (m_ph != 0) begin
      exp_code = 5'b01101; exp_tag = (m_ph == 1) ? "R7" : "R6"; m_ph = 3;
    end else begin
      exp_code = 5'b11111; exp_tag = "R2";
    end
  endtask

  task automatic gap(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 5'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", 5'b11111);
    rst_n = 1'b1;
    exp_code = 5'b11111; exp_tag = "R1";
    // R2: idle with stray error flag and data
    for (int i = 0; i < 4; i++) cyc(1'b0, 1'b1, 4'(i + 5), 1'b0, 1'b0, 5'h0);
    // R3, R4: packet carrying every nibble value
    cyc(1'b1, 1'b0, 4'h5, 1'b0, 1'b0, 5'h0);
    cyc(1'b1, 1'b0, 4'h5, 1'b0, 1'b0, 5'h0);
    for (int i = 0; i < 16; i++) cyc(1'b1, 1'b0, 4'(i), 1'b0, 1'b0, 5'h0);
    gap(4);
    // R5: error in body, in J cycle, in K cycle
    cyc(1'b1, 1'b1, 4'h5, 1'b0, 1'b0, 5'h0);
    cyc(1'b1, 1'b1, 4'h5, 1'b0, 1'b0, 5'h0);
    cyc(1'b1, 1'b0, 4'hA, 1'b0, 1'b0, 5'h0);
    cyc(1'b1, 1'b1, 4'h3, 1'b0, 1'b0, 5'h0);
    cyc(1'b1, 1'b0, 4'hC, 1'b0, 1'b0, 5'h0);
    gap(3);
    // R7: single-cycle packet
    cyc(1'b1, 1'b0, 4'h5, 1'b0, 1'b0, 5'h0);
    gap(4);
    // R6: enable held through the R cycle
    cyc(1'b1, 1'b0, 4'h5, 1'b0, 1'b0, 5'h0);
    cyc(1'b1, 1'b0, 4'h5, 1'b0, 1'b0, 5'h0);
    cyc(1'b1, 1'b0, 4'h7, 1'b0, 1'b0, 5'h0);
    cyc(1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 5'h0);
    for (int i = 0; i < 5; i++) cyc(1'b1, 1'b0, 4'(i + 9), 1'b0, 1'b0, 5'h0);
    gap(3);
    // R8: bypass by config bit, then strap, mid-packet entry and release
    cyc(1'b1, 1'b0, 4'h5, 1'b0, 1'b0, 5'h0);
    cyc(1'b1, 1'b0, 4'h5, 1'b0, 1'b0, 5'h0);
    cyc(1'b1, 1'b0, 4'h2, 1'b0, 1'b0, 5'h0);
    for (int i = 0; i < 6; i++) cyc(1'b1, 1'b1, 4'h4, 1'b1, 1'b0, 5'(i * 5 + 1));
    for (int i = 0; i < 6; i++) cyc(1'b0, 1'b0, 4'h0, 1'b0, 1'b1, 5'(31 - i * 3));
    cyc(1'b1, 1'b0, 4'h6, 1'b1, 1'b1, 5'b00000);
    for (int i = 0; i < 4; i++) cyc(1'b1, 1'b0, 4'(i), 1'b0, 1'b0, 5'h0);
    gap(4);
    @(negedge clk);
    check(exp_tag, exp_code);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule